// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block sits between a trace writer that emits a linear, contiguous write address stream and a memory system in which the trace buffer is scattered over 4 KB physical pages. When translation is enabled, each request address is turned into a physical address. The translator reads 64-bit descriptors from a chain of 4 KB table pages. Each table page maps 1 MB of input space, and the table pages are linked to their neighbours in both directions. When translation is off, addresses go straight through unchanged.

Software fills a small 32-bit register file with the table chain start, the 1 MB-aligned input base, the mode and the enable bit, then sends requests. The translator keeps the address and chain position of the table page it visited last. A lookup that lands in a different 1 MB window moves along the chain one link per descriptor read. A lookup in the same window needs only a single read of the data descriptor. Descriptor reads go out on a valid/ready read port, and the data comes back on a separate valid strobe.

Top module: `lpt_xlate`

## Requirements
- R1: After reset, the control register (word 0) reads 0, the status register (word 1) reads ready (bit 0 = 1), `req_ready_o`, `rd_valid_o` and `resp_valid_o` are low, and bits 5:0 of the identity register (word 7) hold the parameter `PA_W` (default 40).
- R2: With mode bit 0 (word 2) clear and the block enabled, an accepted request produces `resp_valid_o` in the next cycle, carrying the request address unchanged and no error, and no descriptor is read.
- R3: In translate mode (mode bit 0 set), an address A with offset D = A - input base reads the data descriptor at table address + 8*D[19:12] of the table for window D[27:20]. A valid descriptor yields `{desc[63:12], A[11:0]}`.
- R4: A descriptor whose bit 0 is clear ends the lookup with `resp_err_o` set, and no further descriptor is read for that request.
- R5: An address below the input base, or one whose window index does not fit in `TIDX_W` bits, is answered with an error in the next cycle, and no descriptor is read.
- R6: To reach a higher window the translator reads slot 511 (byte 0xFF8) of the current table page. To reach a lower window it reads slot 510 (byte 0xFF0). Each link read moves one step. The position is kept between lookups, so a lookup from window c to window t takes |t-c|+1 reads.
- R7: A link descriptor with bit 0 clear (the end of the chain) gives an error, and the cached position stays at the last table page reached.
- R8: Changing control bit 0 from 0 to 1 resets the cached position to the table base (words 3/4, low/high), window 0. Writing 1 while the block is already enabled leaves the position unchanged.
- R9: While the block is enabled, writes to the mode register and to the table-base and input-base registers (words 3 to 6) are ignored.
- R10: Status bit 0 is low while a lookup is in progress. A request is accepted only when the block is enabled and idle.
- R11: While `rd_ready_i` is low, `rd_valid_o` stays high and `rd_addr_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 64 | Linear input address |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_err_o | output | 1 | Lookup failed |
| resp_addr_o | output | 64 | Physical address |
| rd_valid_o | output | 1 | Descriptor read request |
| rd_ready_i | input | 1 | Memory accepts read request |
| rd_addr_o | output | 64 | Descriptor byte address |
| rd_data_valid_i | input | 1 | Descriptor data strobe |
| rd_data_i | input | 64 | Descriptor data |

## Verification
A pass-through response, or an immediate range error, comes one cycle after the edge at which the request is accepted. A translated response comes 2n+1 cycles after acceptance, where n is the number of descriptor reads, provided memory accepts every read at once and returns data one cycle after acceptance. The bench drives and samples on falling edges. It counts those edges from acceptance until it sees the response strobe, and compares that count, the number of read handshakes and the returned address against a bench model of the chain position. While the bench stalls the read port, it checks on every falling edge that the request is still held.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int AW         = 64;
  localparam int PG_SHIFT   = 12;
  localparam int TBL_SHIFT  = 20;
  localparam int SLOT_W     = TBL_SHIFT - PG_SHIFT;
  localparam int SLOT_IW    = SLOT_W + 1;
  localparam int DESC_SHIFT = 3;
  localparam logic [SLOT_IW-1:0] SLOT_PREV = 9'd510;
  localparam logic [SLOT_IW-1:0] SLOT_NEXT = 9'd511;

  typedef enum logic [1:0] {ST_IDLE, ST_FREQ, ST_FWAIT, ST_RESP} st_e;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0, RG_STAT = 3'd1, RG_MODE = 3'd2, RG_TBL_LO = 3'd3,
    RG_TBL_HI = 3'd4, RG_IN_LO = 3'd5, RG_IN_HI = 3'd6, RG_ID = 3'd7
  } reg_e;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          ready_i,
  output logic          en_o,
  output logic          en_rise_o,
  output logic          xl_o,
  output logic [AW-1:0] tbl_base_o,
  output logic [AW-1:0] in_base_o
);
  logic          en_q, xl_q;
  logic [AW-1:0] tbl_q, in_q;
  reg_e          sel;
  logic [30:0]   unused_wdata;

  assign sel          = reg_e'(addr_i);
  assign unused_wdata = wdata_i[31:1];
  assign en_rise_o    = we_i && sel == RG_CTRL && wdata_i[0] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      xl_q  <= 1'b0;
      tbl_q <= '0;
      in_q  <= '0;
    end else if (we_i) begin
      unique case (sel)
        RG_CTRL:   en_q <= wdata_i[0];
        RG_MODE:   if (!en_q) xl_q <= wdata_i[0];
        RG_TBL_LO: if (!en_q) tbl_q[31:0]  <= wdata_i;
        RG_TBL_HI: if (!en_q) tbl_q[63:32] <= wdata_i;
        RG_IN_LO:  if (!en_q) in_q[31:0]   <= wdata_i;
        RG_IN_HI:  if (!en_q) in_q[63:32]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      RG_CTRL:   rdata_o = {31'b0, en_q};
      RG_STAT:   rdata_o = {31'b0, ready_i};
      RG_MODE:   rdata_o = {31'b0, xl_q};
      RG_TBL_LO: rdata_o = tbl_q[31:0];
      RG_TBL_HI: rdata_o = tbl_q[63:32];
      RG_IN_LO:  rdata_o = in_q[31:0];
      RG_IN_HI:  rdata_o = in_q[63:32];
      default:   rdata_o = {26'b0, 6'(PA_W)};
    endcase
  end

  assign en_o       = en_q;
  assign xl_o       = xl_q;
  assign tbl_base_o = tbl_q;
  assign in_base_o  = in_q;
endmodule

// File: rtl/lpt_addr_split.sv
module lpt_addr_split
  import lpt_pkg::*;
#(
  parameter int TIDX_W = 8
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [AW-1:0]     base_i,
  output logic [TIDX_W-1:0] tidx_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              oor_o
);
  localparam int HI_LSB = TBL_SHIFT + TIDX_W;

  logic [AW-1:0]       off;
  logic [PG_SHIFT-1:0] unused_lo;

  assign off       = addr_i - base_i;
  assign unused_lo = off[PG_SHIFT-1:0];
  assign tidx_o    = off[TBL_SHIFT +: TIDX_W];
  assign slot_o    = off[PG_SHIFT +: SLOT_W];
  assign oor_o     = (addr_i < base_i) || (|off[AW-1:HI_LSB]);
endmodule

// File: rtl/lpt_walker.sv
module lpt_walker
  import lpt_pkg::*;
#(
  parameter int TIDX_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          en_rise_i,
  input  logic          xl_i,
  input  logic [AW-1:0] tbl_base_i,
  input  logic [AW-1:0] in_base_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  output logic          resp_valid_o,
  output logic          resp_err_o,
  output logic [AW-1:0] resp_addr_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_data_valid_i,
  input  logic [AW-1:0] rd_data_i,
  output logic          idle_o
);
  st_e               st_q;
  logic [AW-1:0]     req_q, cur_tbl_q, resp_addr_q;
  logic [TIDX_W-1:0] cur_idx_q;
  logic              resp_err_q;

  logic              in_oor, unused_q_oor;
  logic [TIDX_W-1:0] unused_in_tidx, q_tidx;
  logic [SLOT_W-1:0] unused_in_slot, q_slot;
  logic              go_fwd, go_back;
  logic [SLOT_IW-1:0] slot_sel;
  logic [PG_SHIFT-2:0] unused_desc;

  lpt_addr_split #(.TIDX_W(TIDX_W)) u_in_split (
    .addr_i(req_addr_i), .base_i(in_base_i),
    .tidx_o(unused_in_tidx), .slot_o(unused_in_slot), .oor_o(in_oor)
  );

  lpt_addr_split #(.TIDX_W(TIDX_W)) u_q_split (
    .addr_i(req_q), .base_i(in_base_i),
    .tidx_o(q_tidx), .slot_o(q_slot), .oor_o(unused_q_oor)
  );

  assign unused_desc = rd_data_i[PG_SHIFT-1:1];
  assign go_fwd   = q_tidx > cur_idx_q;
  assign go_back  = q_tidx < cur_idx_q;
  assign slot_sel = go_fwd ? SLOT_NEXT : (go_back ? SLOT_PREV : {1'b0, q_slot});

  assign rd_addr_o    = cur_tbl_q + AW'({slot_sel, {DESC_SHIFT{1'b0}}});
  assign rd_valid_o   = st_q == ST_FREQ;
  assign idle_o       = st_q == ST_IDLE;
  assign req_ready_o  = en_i && st_q == ST_IDLE;
  assign resp_valid_o = st_q == ST_RESP;
  assign resp_err_o   = resp_err_q;
  assign resp_addr_o  = resp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      req_q       <= '0;
      cur_tbl_q   <= '0;
      cur_idx_q   <= '0;
      resp_addr_q <= '0;
      resp_err_q  <= 1'b0;
    end else begin
      if (en_rise_i) begin
        cur_tbl_q <= {tbl_base_i[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
        cur_idx_q <= '0;
      end
      unique case (st_q)
        ST_IDLE: if (req_valid_i && req_ready_o) begin
          req_q <= req_addr_i;
          if (!xl_i) begin
            resp_addr_q <= req_addr_i;
            resp_err_q  <= 1'b0;
            st_q        <= ST_RESP;
          end else if (in_oor) begin
            resp_addr_q <= '0;
            resp_err_q  <= 1'b1;
            st_q        <= ST_RESP;
          end else begin
            st_q <= ST_FREQ;
          end
        end
        ST_FREQ: if (rd_ready_i) st_q <= ST_FWAIT;
        ST_FWAIT: if (rd_data_valid_i) begin
          if (!rd_data_i[0]) begin
            resp_addr_q <= '0;
            resp_err_q  <= 1'b1;
            st_q        <= ST_RESP;
          end else if (go_fwd || go_back) begin
            if (!en_rise_i) begin
              cur_tbl_q <= {rd_data_i[AW-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
              cur_idx_q <= go_fwd ? cur_idx_q + 1'b1 : cur_idx_q - 1'b1;
            end
            st_q <= ST_FREQ;
          end else begin
            resp_addr_q <= {rd_data_i[AW-1:PG_SHIFT], req_q[PG_SHIFT-1:0]};
            resp_err_q  <= 1'b0;
            st_q        <= ST_RESP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpt_xlate.sv
module lpt_xlate
  import lpt_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int TIDX_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [63:0] req_addr_i,
  output logic        resp_valid_o,
  output logic        resp_err_o,
  output logic [63:0] resp_addr_o,
  output logic        rd_valid_o,
  input  logic        rd_ready_i,
  output logic [63:0] rd_addr_o,
  input  logic        rd_data_valid_i,
  input  logic [63:0] rd_data_i
);
  logic          blk_en, en_rise, mode_xl, wk_idle;
  logic [AW-1:0] tbl_base, in_base;

  lpt_regs #(.PA_W(PA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .ready_i(wk_idle),
    .en_o(blk_en), .en_rise_o(en_rise), .xl_o(mode_xl),
    .tbl_base_o(tbl_base), .in_base_o(in_base)
  );

  lpt_walker #(.TIDX_W(TIDX_W)) u_walker (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(blk_en), .en_rise_i(en_rise),
    .xl_i(mode_xl), .tbl_base_i(tbl_base), .in_base_i(in_base),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .resp_valid_o(resp_valid_o), .resp_err_o(resp_err_o), .resp_addr_o(resp_addr_o),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_data_valid_i(rd_data_valid_i), .rd_data_i(rd_data_i), .idle_o(wk_idle)
  );
endmodule

// File: rtl/lpt_xlate_chk.sv
module lpt_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [63:0] req_addr_i,
  input logic        resp_valid_o,
  input logic        resp_err_o,
  input logic [63:0] resp_addr_o,
  input logic        rd_valid_o,
  input logic        rd_ready_i,
  input logic [63:0] rd_addr_o,
  input logic        blk_en,
  input logic        mode_xl,
  input logic [63:0] tbl_base,
  input logic [63:0] in_base
);
  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !mode_xl) |=>
      (resp_valid_o && !resp_err_o && resp_addr_o == $past(req_addr_i)));

  a_r5_below_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && mode_xl && req_addr_i < in_base) |=>
      (resp_valid_o && resp_err_o));

  a_r6_desc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_addr_o[2:0] == 3'b000);

  a_r9_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_en |=> $stable(mode_xl));

  a_r9_bases_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_en |=> ($stable(tbl_base) && $stable(in_base)));

  a_r10_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (blk_en && !rd_valid_o && !resp_valid_o));

  a_r11_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  a_r4_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
endmodule

bind lpt_xlate lpt_xlate_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_addr_i(req_addr_i), .resp_valid_o(resp_valid_o), .resp_err_o(resp_err_o),
  .resp_addr_o(resp_addr_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_addr_o(rd_addr_o), .blk_en(blk_en), .mode_xl(mode_xl),
  .tbl_base(tbl_base), .in_base(in_base)
);

// File: tb/tb_lpt_xlate.sv
module tb_lpt_xlate;
  localparam int NT = 4;
  localparam logic [63:0] TBL0    = 64'h0000_0000_1000_0000;
  localparam logic [63:0] IN_BASE = 64'h0000_0001_0000_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = 3'd1;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        req_valid_i = 1'b0, req_ready_o;
  logic [63:0] req_addr_i = '0;
  logic        resp_valid_o, resp_err_o;
  logic [63:0] resp_addr_o;
  logic        rd_valid_o, rd_ready_i = 1'b1;
  logic [63:0] rd_addr_o;
  logic        rd_data_valid_i = 1'b0;
  logic [63:0] rd_data_i = '0;

  int n_tests = 0, n_fail = 0, nfetch = 0, stall = 0, viol = 0, cur = 0;
  bit done = 0, xl_tb = 0;
  logic [63:0] mem [logic [63:0]];

  lpt_xlate dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [63:0] tb_addr(int k);
    return TBL0 + 64'(k) * 64'h1_0000;
  endfunction
  function automatic bit d_ok(int k, int s);
    return !(k == NT - 1 && s >= 100) && ((k * 256 + s) % 37 != 5);
  endfunction
  function automatic logic [63:0] d_page(int k, int s);
    return 64'h2_0000_0000 + (64'(k * 256 + s) * 3 << 12);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0; reg_addr_i = 3'd1;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; #1 d = reg_rdata_o; reg_addr_i = 3'd1;
  endtask

  // memory model: accepts when not stalled, returns data one cycle after handshake
  initial begin
    bit pend = 0, held = 0;
    logic [63:0] pa = '0, hold = '0;
    forever begin
      @(negedge clk_i);
      rd_data_valid_i = 1'b0;
      if (pend) begin
        rd_data_i = mem.exists(pa) ? mem[pa] : 64'h0;
        rd_data_valid_i = 1'b1;
        pend = 0;
      end
      if (held && !(rd_valid_o && rd_addr_o == hold)) viol++;
      rd_ready_i = (stall == 0);
      if (stall > 0) stall--;
      held = rd_valid_o && !rd_ready_i;
      hold = rd_addr_o;
      if (rd_valid_o && rd_ready_i) begin pend = 1; pa = rd_addr_o; nfetch++; end
    end
  end

  task automatic lookup(logic [63:0] a, bit lat_chk, string tag);
    bit e_err = 0; logic [63:0] e_addr = a; int e_nf = 0, cyc, nf0, t, s;
    if (xl_tb) begin
      if (a < IN_BASE || ((a - IN_BASE) >> 20) >= 256) e_err = 1;
      else begin
        t = int'((a - IN_BASE) >> 20); s = int'(((a - IN_BASE) >> 12) & 255);
        while (cur != t) begin
          e_nf++;
          if (t > cur) begin
            if (cur == NT - 1) begin e_err = 1; break; end
            cur++;
          end else cur--;
        end
        if (!e_err) begin
          e_nf++;
          if (!d_ok(cur, s)) e_err = 1;
          else e_addr = {d_page(cur, s)[63:12], a[11:0]};
        end
      end
    end
    @(negedge clk_i);
    chk(req_ready_o === 1'b1, {tag, " R10 req_ready idle"}, 64'(req_ready_o), 1);
    req_valid_i = 1'b1; req_addr_i = a; nf0 = nfetch;
    @(negedge clk_i);
    req_valid_i = 1'b0; cyc = 1;
    if (xl_tb && e_nf > 0)
      chk(reg_rdata_o[0] == 1'b0, {tag, " R10 status busy"}, 64'(reg_rdata_o[0]), 0);
    while (resp_valid_o !== 1'b1 && cyc < 400) begin @(negedge clk_i); cyc++; end
    chk(resp_valid_o === 1'b1 && resp_err_o === e_err, {tag, " err flag"}, 64'(resp_err_o), 64'(e_err));
    if (!e_err) chk(resp_addr_o === e_addr, {tag, " addr"}, resp_addr_o, e_addr);
    chk(nfetch - nf0 == e_nf, {tag, " R6 fetch count"}, 64'(nfetch - nf0), 64'(e_nf));
    if (lat_chk) chk(cyc == 2 * e_nf + 1, {tag, " latency"}, 64'(cyc), 64'(2 * e_nf + 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int k = 0; k < NT; k++) begin
      for (int s = 0; s < 256; s++)
        mem[tb_addr(k) + 64'(s) * 8] = d_ok(k, s) ? (d_page(k, s) | 64'h1) : 64'h0;
      mem[tb_addr(k) + 64'hFF0] = (k > 0) ? (tb_addr(k - 1) | 64'h1) : 64'h0;
      mem[tb_addr(k) + 64'hFF8] = (k < NT - 1) ? (tb_addr(k + 1) | 64'h1) : 64'h0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'd0, d); chk(d == 0, "R1 ctrl", 64'(d), 0);
    rd(3'd1, d); chk(d[0] == 1'b1, "R1 status ready", 64'(d), 1);
    rd(3'd7, d); chk(d[5:0] == 6'd40, "R1 id width", 64'(d[5:0]), 40);
    chk(req_ready_o == 0 && rd_valid_o == 0 && resp_valid_o == 0, "R1 outputs idle",
        64'({req_ready_o, rd_valid_o, resp_valid_o}), 0);

    // R2 pass-through
    wr(3'd0, 32'h1);
    for (int i = 0; i < 4; i++) lookup({$urandom, $urandom}, 1, "R2 pass");
    wr(3'd0, 32'h0);
    @(negedge clk_i);
    chk(req_ready_o == 1'b0, "R10 no accept when disabled", 64'(req_ready_o), 0);

    wr(3'd2, 32'h1);
    wr(3'd3, TBL0[31:0]); wr(3'd4, TBL0[63:32]);
    wr(3'd5, IN_BASE[31:0]); wr(3'd6, IN_BASE[63:32]);
    wr(3'd0, 32'h1); xl_tb = 1; cur = 0;

    // R9 locked while enabled
    wr(3'd2, 32'h0); rd(3'd2, d); chk(d[0] == 1'b1, "R9 mode locked", 64'(d), 1);
    wr(3'd3, 32'hDEAD_0000); rd(3'd3, d); chk(d == TBL0[31:0], "R9 table base locked", 64'(d), 64'(TBL0[31:0]));
    wr(3'd5, 32'h0); rd(3'd6, d); chk(d == IN_BASE[63:32], "R9 input base locked", 64'(d), 64'(IN_BASE[63:32]));

    lookup(IN_BASE + 64'h123, 1, "R3 window0 slot0");
    lookup(IN_BASE + (64'd5 << 12) + 64'h10, 1, "R4 invalid data desc");
    lookup(IN_BASE + (64'd2 << 20) + (64'd7 << 12) + 64'hABC, 1, "R6 forward two links");
    lookup(IN_BASE + (64'd1 << 20) + (64'd200 << 12) + 64'h7, 1, "R6 back one link");
    lookup(IN_BASE - 64'd1, 1, "R5 below base");
    lookup(IN_BASE + (64'd256 << 20), 1, "R5 window out of range");
    lookup(IN_BASE + (64'd6 << 20), 1, "R7 end of chain");
    lookup(IN_BASE + (64'd3 << 20) + (64'd150 << 12), 1, "R4 unused slot");
    lookup(IN_BASE + (64'd2 << 20) + (64'd9 << 12), 1, "R7 position kept");

    // R8 enable re-write keeps position, re-enable resets it
    wr(3'd0, 32'h1);
    lookup(IN_BASE + (64'd2 << 20) + (64'd11 << 12), 1, "R8 rewrite no reset");
    wr(3'd0, 32'h0); wr(3'd0, 32'h1); cur = 0;
    lookup(IN_BASE + (64'd2 << 20) + (64'd12 << 12), 1, "R8 rise resets");

    // R11 stalled read port
    stall = 4; viol = 0;
    lookup(IN_BASE + (64'd3 << 20) + (64'd3 << 12) + 64'h44, 0, "R11 stalled lookup");
    chk(viol == 0, "R11 request held", 64'(viol), 0);

    for (int i = 0; i < 40; i++) begin
      logic [63:0] a;
      if ($urandom_range(0, 9) == 0) a = IN_BASE - 64'($urandom_range(1, 1 << 20));
      else a = IN_BASE + (64'($urandom_range(0, NT)) << 20) + (64'($urandom_range(0, 255)) << 12)
               + 64'($urandom_range(0, 4095));
      lookup(a, 1, "R3 random");
    end

    wr(3'd0, 32'h0);
    rd(3'd1, d); chk(d[0] == 1'b1, "R10 ready after disable", 64'(d), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule